// File: doc/BRIEF.md
# Two-Wire DAC Command Slave

This block is the serial front end of a single-channel DAC. It sits on a two-wire bus as a write/read slave, takes a 16-bit command word as two bytes, and holds the result as a power-down mode and a left-justified conversion code. The bus lines arrive as oversampled inputs in the system clock domain. The slave pulls the data line low through an open-drain enable. Its seven-bit bus address has fixed upper bits. The two low bits follow a three-level strapping pin, which reaches the block already encoded as a 2-bit level.

A write moves the word into the output registers only after both data bytes have been acknowledged. On that clock the block raises a single-cycle `commit` strobe for the analog side. A read returns the latched word in the same layout. Any frame that is cut short by STOP or by a new START leaves the outputs as they were.

Top module: `dac_i2c_slave`

## Requirements
- R1: After reset, `pd_mode` is 0, `dac_code` is 0, `sda_oe` is 0 and `commit` is 0.
- R2: The device address is 7'b00011 followed by two low bits chosen by `pin_lvl`. Level 0 (grounded) gives 11, level 1 (supply) gives 00, and levels 2 and 3 (open) give 10. No other address is acknowledged, including the all-zero general call.
- R3: On a matching address with R/W=0, the slave acknowledges the address byte and both data bytes by holding SDA low through the ninth SCL pulse. It changes `sda_oe` only while SCL is low.
- R4: In the command word, bit 15 is sent first. Bits 13:12 are the power-down mode. Bits 11 down to 12-DATA_BITS are the code. Bits 15:14 and any bits below the code are ignored.
- R5: `commit` is high for exactly one clock, on the same clock that `pd_mode` and `dac_code` take the new word. This happens once per write, after the SCL falling edge that ends the second data acknowledge. Any further data bytes in that frame are not acknowledged and have no effect.
- R6: For a matching address with R/W=1, the slave sends the latched word MSB first, as 2'b00, the mode, the code, and zero fill. It sends the low byte only if the master acknowledged the high byte. After the master's NACK it releases SDA.
- R7: After a non-matching address, the slave acknowledges nothing and keeps SDA released until the next START. The outputs stay unchanged.
- R8: A STOP or START that arrives before the second data acknowledge has completed discards the partial word. No `commit` is issued and the outputs are unchanged.
- R9: `pd_mode` and `dac_code` change on no clock other than one where `commit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pin_lvl | input | 2 | Encoded strapping-pin level: 0 ground, 1 supply, 2/3 open |
| sda_oe | output | 1 | Pull data line low when 1 |
| pd_mode | output | 2 | Latched power-down mode (0 = normal) |
| dac_code | output | DATA_BITS | Latched conversion code |
| commit | output | 1 | One-cycle strobe when a new word is latched |

## Verification
Every bus edge passes through two synchronizer flops and one state register. `sda_oe`, `commit` and the latched outputs therefore move on the third clock after the bus edge that causes them. The bench holds each SCL half-period for ten clocks and changes or samples SDA at its midpoint, so each acknowledge and each read bit is taken well after the slave has settled. A per-clock monitor applies the pending word on the exact clock `commit` shows. It then compares `pd_mode` and `dac_code` against its own copy on every falling clock edge. Commit counts taken before and after each frame show whether that frame should have latched.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;

    localparam logic [4:0] DEV_ADDR_HI = 5'b00011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_SKIP
    } frame_st_t;

    // strapping level -> low address bits
    function automatic logic [1:0] pin_to_low(input logic [1:0] lvl);
        case (lvl)
            2'd0:    return 2'b11;
            2'd1:    return 2'b00;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [1:0] scl_pipe;
        logic [1:0] sda_pipe;
        logic       scl_prev;
        logic       sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[1];
        s_d.sda_prev = s_q.sda_pipe[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o    = s_q.scl_pipe[1];
    assign sda_o    = s_q.sda_pipe[1];
    assign scl_rise = scl_o & ~s_q.scl_prev;
    assign scl_fall = ~scl_o & s_q.scl_prev;
    assign start_ev = scl_o & s_q.scl_prev & s_q.sda_prev & ~sda_o;
    assign stop_ev  = scl_o & s_q.scl_prev & ~s_q.sda_prev & sda_o;

endmodule

// File: rtl/dac_i2c_frame.sv
module dac_i2c_frame
    import dac_i2c_pkg::*;
#(
    parameter int DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl,
    input  logic                 sda,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_ev,
    input  logic                 stop_ev,
    input  logic [6:0]           dev_addr,
    output logic                 sda_oe,
    output logic [1:0]           pd_mode,
    output logic [DATA_BITS-1:0] dac_code,
    output logic                 commit
);
    localparam int CODE_TOP = 11;

    typedef struct packed {
        frame_st_t            st;
        logic [3:0]           cnt;
        logic [7:0]           sh;
        logic [7:0]           hi;
        logic                 rw;
        logic                 byte1;
        logic                 ack;
        logic                 oe;
        logic [1:0]           pd;
        logic [DATA_BITS-1:0] code;
        logic                 commit;
    } frame_t;

    frame_t f_d, f_q;
    logic [15:0] rb_word;
    logic [15:0] wr_word;

    always_comb begin
        rb_word                          = '0;
        rb_word[13:12]                   = f_q.pd;
        rb_word[CODE_TOP -: DATA_BITS]   = f_q.code;
        wr_word                          = {f_q.hi, f_q.sh};
    end

    always_comb begin
        f_d        = f_q;
        f_d.commit = 1'b0;
        if (start_ev) begin
            f_d.st  = ST_ADDR;
            f_d.cnt = '0;
            f_d.oe  = 1'b0;
        end else if (stop_ev) begin
            f_d.st = ST_IDLE;
            f_d.oe = 1'b0;
        end else begin
            unique case (f_q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        f_d.sh  = {f_q.sh[6:0], sda};
                        f_d.cnt = f_q.cnt + 4'd1;
                    end else if (scl_fall && f_q.cnt == 4'd8) begin
                        f_d.cnt = '0;
                        if (f_q.st == ST_ADDR) begin
                            if (f_q.sh[7:1] == dev_addr) begin
                                f_d.st = ST_AACK;
                                f_d.oe = 1'b1;
                                f_d.rw = f_q.sh[0];
                            end else begin
                                f_d.st = ST_SKIP;
                            end
                        end else begin
                            f_d.st = ST_RACK;
                            f_d.oe = 1'b1;
                            if (!f_q.byte1) f_d.hi = f_q.sh;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        f_d.byte1 = 1'b0;
                        if (f_q.rw) begin
                            f_d.st = ST_TX;
                            f_d.sh = rb_word[15:8];
                            f_d.oe = ~rb_word[15];
                        end else begin
                            f_d.st = ST_RX;
                            f_d.oe = 1'b0;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        f_d.oe = 1'b0;
                        if (f_q.byte1) begin
                            f_d.commit = 1'b1;
                            f_d.pd     = wr_word[13:12];
                            f_d.code   = wr_word[CODE_TOP -: DATA_BITS];
                            f_d.st     = ST_SKIP;
                        end else begin
                            f_d.byte1 = 1'b1;
                            f_d.st    = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        f_d.cnt = f_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (f_q.cnt == 4'd8) begin
                            f_d.cnt = '0;
                            f_d.oe  = 1'b0;
                            f_d.st  = ST_TACK;
                        end else begin
                            f_d.sh = {f_q.sh[6:0], 1'b0};
                            f_d.oe = ~f_q.sh[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        f_d.ack = ~sda;
                    end else if (scl_fall) begin
                        if (f_q.ack && !f_q.byte1) begin
                            f_d.byte1 = 1'b1;
                            f_d.sh    = rb_word[7:0];
                            f_d.oe    = ~rb_word[7];
                            f_d.st    = ST_TX;
                        end else begin
                            f_d.st = ST_SKIP;
                        end
                    end
                end
                default: f_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe   = f_q.oe;
    assign pd_mode  = f_q.pd;
    assign dac_code = f_q.code;
    assign commit   = f_q.commit;

    // R3
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl);

    // R5
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe && !commit));

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> ($stable(pd_mode) && $stable(dac_code)));

endmodule

// File: rtl/dac_i2c_slave.sv
module dac_i2c_slave
    import dac_i2c_pkg::*;
#(
    parameter int DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [1:0]           pin_lvl,
    output logic                 sda_oe,
    output logic [1:0]           pd_mode,
    output logic [DATA_BITS-1:0] dac_code,
    output logic                 commit
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [6:0] dev_addr;

    assign dev_addr = {DEV_ADDR_HI, pin_to_low(pin_lvl)};

    // R2
    always_comb begin
        addr_map_chk: assert (dev_addr[1:0] != 2'b01);
    end

    i2c_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_o    (scl_s),
        .sda_o    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    dac_i2c_frame #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_s),
        .sda      (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .dev_addr (dev_addr),
        .sda_oe   (sda_oe),
        .pd_mode  (pd_mode),
        .dac_code (dac_code),
        .commit   (commit)
    );

endmodule

// File: tb/dac_i2c_slave_test.sv
module dac_i2c_slave_test;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  pin_lvl = 2'd0;
    logic        sda_oe;
    logic [1:0]  pd_mode;
    logic [11:0] dac_code;
    logic        commit;
    logic        sda_bus;

    int errors = 0;
    int checks = 0;
    int commit_cnt = 0;
    logic        mon_on = 1'b0;
    logic [15:0] pend_word = '0;
    logic [1:0]  exp_pd = '0;
    logic [11:0] exp_code = '0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    dac_i2c_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .pin_lvl  (pin_lvl),
        .sda_oe   (sda_oe),
        .pd_mode  (pd_mode),
        .dac_code (dac_code),
        .commit   (commit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock reference model (R5, R9)
    always @(negedge clk) begin
        if (mon_on) begin
            if (commit) begin
                commit_cnt++;
                exp_pd   = pend_word[13:12];
                exp_code = pend_word[11:0];
            end
            chk(pd_mode == exp_pd, "R9", "pd_mode", pd_mode, exp_pd);
            chk(dac_code == exp_code, "R9", "dac_code", dac_code, exp_code);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_c(input logic b, output logic r);
        sda_m = b; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        r = sda_bus; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic byte_w(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_c(b[i], r);
        bit_c(1'b1, r);
        ack = ~r;
    endtask

    task automatic byte_r(input logic mack, output logic [7:0] v);
        logic r;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_c(1'b1, r);
            v = {v[6:0], r};
        end
        bit_c(~mack, r);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] w, input bit match);
        logic ak;
        int c0;
        c0 = commit_cnt;
        if (match) pend_word = w;
        start_c();
        byte_w({a, 1'b0}, ak);
        chk(ak == match, match ? "R3" : "R7", "address ack", ak, match);
        byte_w(w[15:8], ak);
        chk(ak == match, match ? "R3" : "R7", "high byte ack", ak, match);
        byte_w(w[7:0], ak);
        chk(ak == match, match ? "R3" : "R7", "low byte ack", ak, match);
        stop_c();
        tick(4);
        chk(commit_cnt == c0 + int'(match), "R5", "commit count", commit_cnt, c0 + int'(match));
    endtask

    task automatic rd(input logic [6:0] a, input logic [15:0] exp, input bit match);
        logic ak;
        logic [7:0] hi, lo;
        start_c();
        byte_w({a, 1'b1}, ak);
        chk(ak == match, "R2", "read address ack", ak, match);
        if (match) begin
            byte_r(1'b1, hi);
            byte_r(1'b0, lo);
            chk({hi, lo} == exp, "R6", "readback word", {hi, lo}, exp);
            chk(sda_oe == 1'b0, "R6", "released after nack", sda_oe, 0);
        end
        stop_c();
    endtask

    initial begin
        logic ak;
        int c0;
        tick(5);
        chk(pd_mode == 2'd0 && dac_code == 12'd0, "R1", "reset outputs", {pd_mode, dac_code}, 0);
        chk(sda_oe == 1'b0 && commit == 1'b0, "R1", "reset oe/commit", {sda_oe, commit}, 0);
        rst_n = 1'b1;
        tick(5);
        mon_on = 1'b1;

        // grounded pin: address 0x0F (R2, R3, R4, R5)
        wr(7'h0F, 16'h1ABC, 1'b1);
        rd(7'h0F, 16'h1ABC, 1'b1);
        // reserved bits ignored, zero on readback (R4, R6)
        wr(7'h0F, 16'hF5A3, 1'b1);
        rd(7'h0F, 16'h35A3, 1'b1);
        // other address and general call not acknowledged (R2, R7)
        wr(7'h0C, 16'h2222, 1'b0);
        wr(7'h00, 16'h2222, 1'b0);
        rd(7'h0E, 16'h0, 1'b0);

        // supply pin -> 0x0C, open pin -> 0x0E (R2)
        pin_lvl = 2'd1;
        wr(7'h0C, 16'h2001, 1'b1);
        wr(7'h0F, 16'h1111, 1'b0);
        pin_lvl = 2'd2;
        wr(7'h0E, 16'h0FFF, 1'b1);
        rd(7'h0E, 16'h0FFF, 1'b1);
        pin_lvl = 2'd3;
        rd(7'h0E, 16'h0FFF, 1'b1);
        wr(7'h0F, 16'h1111, 1'b0);

        // R8: STOP after first data byte
        c0 = commit_cnt;
        start_c();
        byte_w({7'h0E, 1'b0}, ak);
        byte_w(8'h12, ak);
        stop_c();
        tick(4);
        chk(commit_cnt == c0, "R8", "stop abort commit", commit_cnt, c0);
        rd(7'h0E, 16'h0FFF, 1'b1);

        // R8: repeated START mid-word, then a full write
        c0 = commit_cnt;
        pend_word = 16'h2468;
        start_c();
        byte_w({7'h0E, 1'b0}, ak);
        byte_w(8'h35, ak);
        start_c();
        byte_w({7'h0E, 1'b0}, ak);
        chk(ak == 1'b1, "R8", "address after restart", ak, 1);
        byte_w(8'h24, ak);
        byte_w(8'h68, ak);
        // R5: extra byte not acknowledged, no effect
        byte_w(8'h3F, ak);
        chk(ak == 1'b0, "R5", "third byte nack", ak, 0);
        stop_c();
        tick(4);
        chk(commit_cnt == c0 + 1, "R5", "single commit", commit_cnt, c0 + 1);
        rd(7'h0E, 16'h2468, 1'b1);

        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule